// File: doc/BRIEF.md
# Serial Audio Frame Transmitter (two-channel and multi-slot)

The block is a clock master that turns parallel audio samples into a serial bit stream. It produces its own bit clock, its own frame marker and the data line from the system clock. The frame marker has two forms. In two-channel mode it is a level that tells left from right. In multi-slot mode it is a pulse at the start of each frame, and a frame holds one to eight slots.

Each frame is built from a set of settings. These settings are the slot width, how many low bits are forced to zero, the slot count, which slots carry data, the marker pulse width, a lead-in delay before the first data bit, the bit order, and the bit-clock edge on which data changes. The block reads all of these settings only when a new frame starts.

Samples come in over a valid/ready handshake. The block takes one sample for each enabled slot, in the system-clock cycle just before that slot's first bit. If no sample is offered at that moment, the block sends a slot of zeros and raises a sticky error flag.

Top module: `tdm_tx`

## Requirements
- R1: While reset is held and after it is released, `sclk_o`, `sync_o`, `sdata_o`, `smp_ready_o` and `underflow_o` are 0. The bit clock then runs with a period of 2*HALF_DIV system cycles. Each period starts with a rising edge, and the clock stays high for the first HALF_DIV cycles.
- R2: Slot width in bits is 4*code+4 for `cfg_size_i` codes 1..7, which gives 8, 12, 16, 20, 24, 28 and 32 bits. Code 0 is treated as 8 bits. A frame lasts `cfg_offset_i` + slots*width bit periods.
- R3: In multi-slot mode (`cfg_tdm_i`=1) the frame has `cfg_slots_i`+1 slots. `sync_o` is 1 during the first `cfg_sync_w_i`+1 bit periods of the frame. If the frame is shorter than that, `sync_o` is 1 for the whole frame.
- R4: In two-channel mode (`cfg_tdm_i`=0) the frame always has 2 slots, and `cfg_slots_i` is ignored. Slot 0 is left and slot 1 is right; the lead-in bits count as left. `sync_o` equals channel XOR `cfg_lr_pol_i`.
- R5: Each slot is sent as a word W of `width` bits. The low `width`-`cfg_mask_i` bits of the sample are placed in W starting at bit `cfg_mask_i`. All other bits of W are 0. When `cfg_lsb_first_i`=0, W is sent from bit `width`-1 down to bit 0.
- R6: When `cfg_lsb_first_i`=1, W is sent from bit 0 up to bit `width`-1.
- R7: When `cfg_neg_edge_i`=0, `sdata_o` changes in the same cycle that `sclk_o` rises. When it is 1, `sdata_o` changes when `sclk_o` falls, carrying the same bit half a period later.
- R8: During lead-in bits and during slots whose `cfg_slot_en_i` bit is 0, `sdata_o` is 0. `smp_ready_o` is high for exactly one cycle, the cycle before `sclk_o` rises for the first bit of an enabled slot. It is never high at any other time.
- R9: When `smp_ready_o` is high and `smp_valid_i` is low, that slot sends zeros and `underflow_o` goes to 1. `underflow_o` then stays 1 until reset.
- R10: All `cfg_*` inputs are read only at the bit-clock edge that starts a frame. A change made in the middle of a frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_tdm_i | input | 1 | 0 two-channel level framing, 1 multi-slot pulse framing |
| cfg_size_i | input | 3 | Slot width code |
| cfg_mask_i | input | 3 | Number of low bits forced to zero |
| cfg_slots_i | input | 3 | Slot count minus one (multi-slot mode) |
| cfg_slot_en_i | input | 8 | Per-slot data enable, bit n for slot n |
| cfg_sync_w_i | input | 8 | Sync pulse width minus one, in bit periods |
| cfg_offset_i | input | 11 | Lead-in bit periods before slot 0 |
| cfg_lsb_first_i | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| cfg_neg_edge_i | input | 1 | Data launch: 0 rising edge, 1 falling edge |
| cfg_lr_pol_i | input | 1 | 0 left marked low, 1 right marked low |
| smp_data_i | input | 32 | Sample, right-justified |
| smp_valid_i | input | 1 | Sample offered |
| smp_ready_o | output | 1 | Sample taken this cycle |
| sclk_o | output | 1 | Bit clock |
| sync_o | output | 1 | Channel level or frame pulse |
| sdata_o | output | 1 | Serial data |
| underflow_o | output | 1 | Sticky missed-sample flag |

## Verification
The checker module tests several timing rules on every cycle. These are the half-period spacing of the bit clock, data changing only on bit-clock edges, `sync_o` changing only on a rising edge, `smp_ready_o` being followed by a rising edge, and the rule that sets the underflow flag and keeps it set. Some behaviour cannot be expressed as a per-cycle property. This covers the bit content of each slot, the masking and the two bit orders, the slot enables, the frame length for each width code, and the rule that settings apply only at frame boundaries. The bench's cycle model checks these over a series of settings, including settings that are changed in the middle of a frame.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int SAMPLE_W = 32;
  localparam int SLOT_N   = 8;
  localparam int SLOT_W   = $clog2(SLOT_N);
  localparam int SIZE_W   = 3;
  localparam int MASK_W   = 3;
  localparam int SYNC_W   = 8;
  localparam int OFF_W    = 11;
  localparam int SBIT_W   = $clog2(SAMPLE_W);
  localparam int CBITS_W  = SBIT_W + 1;
  localparam int POS_W    = $clog2((1 << OFF_W) + SLOT_N * SAMPLE_W);

  typedef struct packed {
    logic                tdm;
    logic [SIZE_W-1:0]   size;
    logic [MASK_W-1:0]   mask;
    logic [SLOT_W-1:0]   slots_m1;
    logic [SLOT_N-1:0]   slot_en;
    logic [SYNC_W-1:0]   sync_w;
    logic [OFF_W-1:0]    offset;
    logic                lsb_first;
    logic                neg_edge;
    logic                lr_pol;
  } cfg_t;

  function automatic logic [CBITS_W-1:0] cont_bits(logic [SIZE_W-1:0] code);
    if (code == '0) return CBITS_W'(8);
    return CBITS_W'({code, 2'b00}) + CBITS_W'(4);
  endfunction

  // sample low bits kept, shifted up past the zeroed tail
  function automatic logic [SAMPLE_W-1:0] pack_word(logic [SAMPLE_W-1:0] s,
                                                    logic [SIZE_W-1:0] code,
                                                    logic [MASK_W-1:0] m);
    logic [SAMPLE_W:0]    keep;
    logic [CBITS_W-1:0]   vb;
    vb   = cont_bits(code) - CBITS_W'(m);
    keep = ((SAMPLE_W+1)'(1) << vb) - (SAMPLE_W+1)'(1);
    return (s & keep[SAMPLE_W-1:0]) << m;
  endfunction
endpackage

// File: rtl/tdm_tx_bitclk.sv
module tdm_tx_bitclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o,
  output logic half_o,
  output logic sclk_o
);
  localparam int PER   = 2 * HALF_DIV;
  localparam int CNT_W = $clog2(PER);

  logic [CNT_W-1:0] cnt_q;
  logic             sclk_q;

  assign step_o = (cnt_q == CNT_W'(PER - 1));
  assign half_o = (cnt_q == CNT_W'(HALF_DIV - 1));
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q <= step_o ? '0 : cnt_q + CNT_W'(1);
      if (step_o)      sclk_q <= 1'b1;
      else if (half_o) sclk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
  import tdm_tx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  cfg_t                cfg_in_i,
  output cfg_t                cfg_eff_o,
  output logic                cur_neg_o,
  output logic                nxt_in_o,
  output logic [SLOT_W-1:0]   nxt_slot_o,
  output logic [SBIT_W-1:0]   nxt_sbit_o,
  output logic                slot_start_o,
  output logic                sync_o
);
  cfg_t                cfg_q;
  logic                first_q, in_q, sync_q;
  logic [POS_W-1:0]    pos_q, n_pos;
  logic [SLOT_W-1:0]   slot_q, n_slot, last_slot_q;
  logic [SBIT_W-1:0]   sbit_q, n_sbit;
  logic [CBITS_W-1:0]  cb_q;
  logic                n_in, wrap, slot_end, sync_n;

  assign cb_q        = cont_bits(cfg_q.size);
  assign last_slot_q = cfg_q.tdm ? cfg_q.slots_m1 : SLOT_W'(1);
  assign slot_end    = ({1'b0, sbit_q} == cb_q - CBITS_W'(1));
  assign wrap        = first_q | (in_q & (slot_q == last_slot_q) & slot_end);
  // new settings take effect on the first bit of a frame
  assign cfg_eff_o   = wrap ? cfg_in_i : cfg_q;

  always_comb begin
    n_pos  = pos_q + POS_W'(1);
    n_in   = in_q;
    n_slot = slot_q;
    n_sbit = sbit_q + SBIT_W'(1);
    if (wrap) begin
      n_pos  = '0;
      n_in   = (cfg_in_i.offset == '0);
      n_slot = '0;
      n_sbit = '0;
    end else if (!in_q) begin
      n_in   = (n_pos == POS_W'(cfg_q.offset));
      n_slot = '0;
      n_sbit = '0;
    end else if (slot_end) begin
      n_slot = slot_q + SLOT_W'(1);
      n_sbit = '0;
    end
  end

  assign sync_n = cfg_eff_o.tdm ? (n_pos <= POS_W'(cfg_eff_o.sync_w))
                                : ((n_in & n_slot[0]) ^ cfg_eff_o.lr_pol);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      first_q <= 1'b1;
      in_q    <= 1'b0;
      pos_q   <= '0;
      slot_q  <= '0;
      sbit_q  <= '0;
      sync_q  <= 1'b0;
    end else if (step_i) begin
      cfg_q   <= cfg_eff_o;
      first_q <= 1'b0;
      in_q    <= n_in;
      pos_q   <= n_pos;
      slot_q  <= n_slot;
      sbit_q  <= n_sbit;
      sync_q  <= sync_n;
    end
  end

  assign cur_neg_o    = cfg_q.neg_edge;
  assign nxt_in_o     = n_in;
  assign nxt_slot_o   = n_slot;
  assign nxt_sbit_o   = n_sbit;
  assign slot_start_o = n_in & (n_sbit == '0);
  assign sync_o       = sync_q;
endmodule

// File: rtl/tdm_tx_slot.sv
module tdm_tx_slot
  import tdm_tx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic                 half_i,
  input  logic [SLOT_N-1:0]    slot_en_i,
  input  logic [SIZE_W-1:0]    size_i,
  input  logic [MASK_W-1:0]    mask_i,
  input  logic                 lsb_first_i,
  input  logic                 neg_eff_i,
  input  logic                 neg_cur_i,
  input  logic                 nxt_in_i,
  input  logic [SLOT_W-1:0]    nxt_slot_i,
  input  logic [SBIT_W-1:0]    nxt_sbit_i,
  input  logic                 slot_start_i,
  input  logic [SAMPLE_W-1:0]  smp_data_i,
  input  logic                 smp_valid_i,
  output logic                 smp_ready_o,
  output logic                 sdata_o,
  output logic                 underflow_o
);
  logic [SAMPLE_W-1:0] word_q, word_n;
  logic [CBITS_W-1:0]  cb;
  logic [SBIT_W-1:0]   idx;
  logic                load, en, bit_n, pend_q, sdata_q, uf_q;

  assign en          = slot_en_i[nxt_slot_i];
  assign load        = step_i & slot_start_i;
  assign smp_ready_o = load & en;
  assign word_n      = !load ? word_q
                     : (en & smp_valid_i) ? pack_word(smp_data_i, size_i, mask_i) : '0;
  assign cb          = cont_bits(size_i);
  assign idx         = lsb_first_i ? nxt_sbit_i
                     : SBIT_W'(cb - CBITS_W'(1) - CBITS_W'(nxt_sbit_i));
  assign bit_n       = nxt_in_i & word_n[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      pend_q  <= 1'b0;
      sdata_q <= 1'b0;
      uf_q    <= 1'b0;
    end else begin
      if (step_i) begin
        word_q <= word_n;
        pend_q <= bit_n;
        if (!neg_eff_i) sdata_q <= bit_n;
      end else if (half_i && neg_cur_i) begin
        sdata_q <= pend_q;
      end
      if (smp_ready_o && !smp_valid_i) uf_q <= 1'b1;
    end
  end

  assign sdata_o     = sdata_q;
  assign underflow_o = uf_q;
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_tdm_i,
  input  logic [2:0]          cfg_size_i,
  input  logic [2:0]          cfg_mask_i,
  input  logic [2:0]          cfg_slots_i,
  input  logic [7:0]          cfg_slot_en_i,
  input  logic [7:0]          cfg_sync_w_i,
  input  logic [10:0]         cfg_offset_i,
  input  logic                cfg_lsb_first_i,
  input  logic                cfg_neg_edge_i,
  input  logic                cfg_lr_pol_i,
  input  logic [31:0]         smp_data_i,
  input  logic                smp_valid_i,
  output logic                smp_ready_o,
  output logic                sclk_o,
  output logic                sync_o,
  output logic                sdata_o,
  output logic                underflow_o
);
  cfg_t                cfg_in, cfg_eff;
  logic                step, half, cur_neg, nxt_in, slot_start;
  logic [SLOT_W-1:0]   nxt_slot;
  logic [SBIT_W-1:0]   nxt_sbit;

  always_comb begin
    cfg_in.tdm       = cfg_tdm_i;
    cfg_in.size      = cfg_size_i;
    cfg_in.mask      = cfg_mask_i;
    cfg_in.slots_m1  = cfg_slots_i;
    cfg_in.slot_en   = cfg_slot_en_i;
    cfg_in.sync_w    = cfg_sync_w_i;
    cfg_in.offset    = cfg_offset_i;
    cfg_in.lsb_first = cfg_lsb_first_i;
    cfg_in.neg_edge  = cfg_neg_edge_i;
    cfg_in.lr_pol    = cfg_lr_pol_i;
  end

  tdm_tx_bitclk #(.HALF_DIV(HALF_DIV)) u_bitclk (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .step_o(step),  .half_o(half), .sclk_o(sclk_o)
  );

  tdm_tx_framer u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .cfg_in_i    (cfg_in),
    .cfg_eff_o   (cfg_eff),
    .cur_neg_o   (cur_neg),
    .nxt_in_o    (nxt_in),
    .nxt_slot_o  (nxt_slot),
    .nxt_sbit_o  (nxt_sbit),
    .slot_start_o(slot_start),
    .sync_o      (sync_o)
  );

  tdm_tx_slot u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .half_i      (half),
    .slot_en_i   (cfg_eff.slot_en),
    .size_i      (cfg_eff.size),
    .mask_i      (cfg_eff.mask),
    .lsb_first_i (cfg_eff.lsb_first),
    .neg_eff_i   (cfg_eff.neg_edge),
    .neg_cur_i   (cur_neg),
    .nxt_in_i    (nxt_in),
    .nxt_slot_i  (nxt_slot),
    .nxt_sbit_i  (nxt_sbit),
    .slot_start_i(slot_start),
    .smp_data_i  (smp_data_i),
    .smp_valid_i (smp_valid_i),
    .smp_ready_o (smp_ready_o),
    .sdata_o     (sdata_o),
    .underflow_o (underflow_o)
  );
endmodule

// File: rtl/tdm_tx_checks.sv
module tdm_tx_checks #(
  parameter int HALF_DIV = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic sync_o,
  input logic sdata_o,
  input logic smp_ready_o,
  input logic smp_valid_i,
  input logic underflow_o
);
  localparam int HC_W = $clog2(HALF_DIV + 2) + 1;

  logic            sclk_d, seen_q, chg;
  logic [HC_W-1:0] hc_q;

  assign chg = sclk_o != sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      seen_q <= 1'b0;
      hc_q   <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (chg) seen_q <= 1'b1;
      if (chg) hc_q <= HC_W'(1);
      else if (hc_q != '1) hc_q <= hc_q + HC_W'(1);
    end
  end

  assert_sclk_half_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && seen_q) |-> (hc_q == HC_W'(HALF_DIV)));

  assert_data_on_sclk_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> !$stable(sclk_o));

  // covers both the pulse (R3) and the level (R4) forms of the marker
  assert_sync_on_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sync_o) |-> $rose(sclk_o));

  assert_ready_before_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ready_o |=> $rose(sclk_o));

  assert_underflow_on_miss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_ready_o && !smp_valid_i) |=> underflow_o);

  assert_underflow_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
endmodule

bind tdm_tx tdm_tx_checks #(.HALF_DIV(HALF_DIV)) u_checks (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sclk_o     (sclk_o),
  .sync_o     (sync_o),
  .sdata_o    (sdata_o),
  .smp_ready_o(smp_ready_o),
  .smp_valid_i(smp_valid_i),
  .underflow_o(underflow_o)
);

// File: tb/tb_tdm_tx.sv
`timescale 1ns/1ps
module tb_tdm_tx;
  localparam int HALF = 2;
  localparam int PER  = 2 * HALF;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_tdm = 0, cfg_lsb = 0, cfg_neg = 0, cfg_pol = 0;
  logic [2:0] cfg_size = 3, cfg_mask = 0, cfg_slots = 0;
  logic [7:0] cfg_en = 8'h03, cfg_sw = 0;
  logic [10:0] cfg_off = 0;
  logic [31:0] smp_data = 0;
  logic smp_valid = 1'b1;
  logic smp_ready, sclk, sync, sdata, uf;

  int errors = 0, checks = 0;
  bit done = 0, run_chk = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  tdm_tx #(.HALF_DIV(HALF)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_tdm_i(cfg_tdm), .cfg_size_i(cfg_size), .cfg_mask_i(cfg_mask),
    .cfg_slots_i(cfg_slots), .cfg_slot_en_i(cfg_en), .cfg_sync_w_i(cfg_sw),
    .cfg_offset_i(cfg_off), .cfg_lsb_first_i(cfg_lsb), .cfg_neg_edge_i(cfg_neg),
    .cfg_lr_pol_i(cfg_pol), .smp_data_i(smp_data), .smp_valid_i(smp_valid),
    .smp_ready_o(smp_ready), .sclk_o(sclk), .sync_o(sync), .sdata_o(sdata),
    .underflow_o(uf)
  );

  function automatic logic [31:0] mix(int n);
    logic [31:0] x;
    x = n * 32'h9E3779B1 + 32'h0BADF00D;
    return x ^ (x >> 13);
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_div, m_pos, m_flen, n_took;
  bit m_first;
  int c_C, c_M, c_nsl, c_w, c_off;
  bit c_tdm, c_lsb, c_neg, c_pol;
  logic [7:0] c_en;
  logic [31:0] m_word;
  logic e_sclk, e_sync, e_sdata, e_uf, m_pend, e_rdy;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_div = 0; m_first = 1; m_pos = 0; m_flen = 1; n_took = 0;
      e_sclk = 0; e_sync = 0; e_sdata = 0; e_uf = 0; m_pend = 0; m_word = 0;
      c_neg = 0;
    end else begin
      e_rdy = 0;
      if (m_div == PER - 1) begin
        int d, slot, b;
        logic bt;
        if (m_first || m_pos == m_flen - 1) begin
          c_tdm = cfg_tdm; c_lsb = cfg_lsb; c_neg = cfg_neg; c_pol = cfg_pol;
          c_C = (cfg_size == 0) ? 8 : 4 * int'(cfg_size) + 4;
          c_M = cfg_mask; c_en = cfg_en; c_w = cfg_sw; c_off = cfg_off;
          c_nsl = cfg_tdm ? int'(cfg_slots) + 1 : 2;
          m_flen = c_off + c_nsl * c_C;
          m_pos = 0; m_first = 0;
        end else m_pos++;
        d = m_pos - c_off;
        slot = (d >= 0) ? d / c_C : -1;
        b = (d >= 0) ? d % c_C : 0;
        if (slot >= 0 && b == 0) begin
          if (c_en[slot]) begin
            e_rdy = 1;
            m_word = 0;
            if (smp_valid) begin
              for (int i = 0; i < c_C - c_M; i++) m_word[i + c_M] = smp_data[i];
              n_took++;
            end else e_uf = 1;
          end else m_word = 0;
        end
        bt = (slot < 0) ? 1'b0 : (c_lsb ? m_word[b] : m_word[c_C - 1 - b]);
        e_sync = c_tdm ? (m_pos <= c_w) : (((slot < 0) ? 1'b0 : slot[0]) ^ c_pol);
        e_sclk = 1;
        if (!c_neg) e_sdata = bt;
        m_pend = bt;
      end else if (m_div == HALF - 1) begin
        e_sclk = 0;
        if (c_neg) e_sdata = m_pend;
      end
      if (run_chk) chk("R8", "smp_ready_o", smp_ready, e_rdy);
      m_div = (m_div + 1) % PER;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && run_chk) begin
      chk("R1", "sclk_o", sclk, e_sclk);
      chk(tag, "sync_o", sync, e_sync);
      chk(tag, "sdata_o", sdata, e_sdata);
      chk("R9", "underflow_o", uf, e_uf);
    end
    smp_data <= mix(n_took);
  end

  task automatic set_cfg(bit tdm, int size, int mask, int slots, int en, int sw,
                         int off, bit lsb, bit neg, bit pol);
    @(negedge clk);
    cfg_tdm = tdm; cfg_size = 3'(size); cfg_mask = 3'(mask); cfg_slots = 3'(slots);
    cfg_en = 8'(en); cfg_sw = 8'(sw); cfg_off = 11'(off);
    cfg_lsb = lsb; cfg_neg = neg; cfg_pol = pol;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset sclk_o", sclk, 1'b0);
    chk("R1", "reset sync_o", sync, 1'b0);
    chk("R1", "reset sdata_o", sdata, 1'b0);
    chk("R1", "reset smp_ready_o", smp_ready, 1'b0);
    chk("R1", "reset underflow_o", uf, 1'b0);
    rst_ni = 1'b1;
    run_chk = 1;
    // two-channel, 16-bit, one lead-in bit, left low
    tag = "R2/R4/R5";
    set_cfg(0, 3, 0, 5, 8'h03, 0, 1, 0, 0, 0);
    wait_cyc(900);
    // right low, 24-bit with 4 zeroed bits, right slot disabled
    tag = "R4/R5/R8";
    set_cfg(0, 5, 4, 0, 8'h01, 0, 0, 0, 0, 1);
    wait_cyc(1000);
    // 8 slots of 8 bits, sparse enables, 1-bit pulse
    tag = "R3/R8";
    set_cfg(1, 1, 0, 7, 8'hA5, 0, 0, 0, 0, 0);
    wait_cyc(1200);
    // 3 slots of 32 bits, LSB first, falling-edge launch, lead-in and wide pulse
    tag = "R6/R7/R3";
    set_cfg(1, 7, 2, 2, 8'h07, 5, 2, 1, 1, 0);
    wait_cyc(1600);
    // settings churned mid-frame; only frame-start values count
    tag = "R10";
    for (int k = 0; k < 30; k++) begin
      set_cfg(1, (k % 2) ? 2 : 6, k % 3, 3, 8'h0F, 2, 3, k % 2, (k / 2) % 2, 0);
      wait_cyc(37 + k);
    end
    wait_cyc(1200);
    // width code 0 gives 8 bits, single slot, pulse longer than the frame
    tag = "R2/R3";
    set_cfg(1, 0, 0, 0, 8'h01, 200, 0, 0, 0, 0);
    wait_cyc(400);
    chk("R9", "no underflow yet", uf, 1'b0);
    // starve the source
    tag = "R9";
    set_cfg(1, 3, 1, 3, 8'h0B, 1, 0, 0, 0, 1);
    wait_cyc(300);
    smp_valid = 1'b0;
    wait_cyc(700);
    chk("R9", "underflow raised", uf, 1'b1);
    smp_valid = 1'b1;
    wait_cyc(600);
    chk("R9", "underflow still set", uf, 1'b1);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule